// File: doc/BRIEF.md
# Reversible Key Evolution Stage

This block holds a 96-bit cipher key as a matrix of three rows by four columns of bytes and moves it one stage along the key schedule on every clock in which a step is requested. Stepping can run in either direction. In the forward (encrypt) direction a 32-bit round constant is XORed into the top row and the rows are then rotated. In the backward (decrypt) direction the inverse rotation comes first and the same constant XOR comes last. Because the backward step exactly undoes the forward step, one key register serves both directions of the cipher.

The linear mixing transform of the schedule is built outside this block. The stage sends out the value that would enter the mixing (`hook_out_o`) and takes the mixed value back on `hook_in_i`. With the hook tied straight back (`hook_in_i = hook_out_o`), the stage runs constant injection and rotation alone. The user key is loaded at the same moment as the data block. A 4-bit round index selects one of ten constants held in a module parameter.

Top module: `kev_evolve`

## Requirements
- R1: Once reset is released, `key_o` is all zeros until a load or a step.
- R2: When `load_i` is high, `key_o` equals `key_i` after the clock edge, whatever `step_i` is. Key matrix element (row i, column j) is byte i+3j, which sits at bits [8(i+3j)+7 : 8(i+3j)].
- R3: A forward step (`fwd_i`=1) XORs constant byte j (constant bits [8j+7:8j]) into element (0,j) before the rotation. The constant does not reach rows 1 and 2.
- R4: Forward rotation leaves row 0 in place. Row 1 moves one byte left: new (1,j) = old (1,(j+1) mod 4). Row 2 moves one byte right: new (2,j) = old (2,(j+3) mod 4). The rotated value appears on `hook_out_o`.
- R5: In a backward step (`fwd_i`=0), `hook_out_o` equals the current key. The hook result is inverse-rotated (row 1 right, row 2 left) and the row-0 constant XOR is applied last.
- R6: The round index selects constant number `round_i` for values 0 to 9. Values 10 to 15 select constant 9.
- R7: When neither `load_i` nor `step_i` is high, `key_o` is unchanged.
- R8: A forward step followed by a backward step with the same round index restores the original key.
- R9: A forward step registers `hook_in_i` as the new key, so an external mixing result is taken unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Capture `key_i` into the key register |
| key_i | input | 96 | User key, byte n at bits [8n+7:8n] |
| step_i | input | 1 | Advance the key by one stage |
| fwd_i | input | 1 | 1 = forward (encrypt) step, 0 = backward (decrypt) step |
| round_i | input | 4 | Round index that selects the constant |
| hook_in_i | input | 96 | Value returned from the external mixing transform |
| hook_out_o | output | 96 | Value sent to the external mixing transform |
| key_o | output | 96 | Current key stage |

## Verification
The assertions assume that the mixing hook is purely combinational and settles within the same cycle. They also assume that `load_i`, `step_i`, `fwd_i` and `round_i` stay steady around each rising edge. The bench drives every input on the falling edge and builds `hook_in_i` from `hook_out_o` XORed with a tweak value that it controls. The tweak is zero except in the hook test, so the combinational return path always stays consistent. The forward-hook and rotation properties only constrain cycles with `fwd_i` high. Backward steps are checked against the bench model.

// File: rtl/kev_pkg.sv
package kev_pkg;
  typedef enum logic {
    KEV_BWD = 1'b0,
    KEV_FWD = 1'b1
  } kev_dir_e;

  // Bit offset of element (row, col) in a column-major byte matrix
  function automatic int kev_elem_lsb(input int row, input int col,
                                      input int rows, input int bw);
    return bw * (row + rows * col);
  endfunction
endpackage

// File: rtl/kev_rst_sync.sv
module kev_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/kev_rcon_sel.sv
module kev_rcon_sel #(
  parameter int NCONST = 10,
  parameter int ROWW   = 32,
  parameter int IDXW   = 4,
  parameter logic [NCONST*ROWW-1:0] RCON_TBL = '0
) (
  input  logic [IDXW-1:0] round_i,
  output logic [ROWW-1:0] rc_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NCONST - 1);

  logic [IDXW-1:0] sel;

  // R6: indices past the last entry saturate
  always_comb begin
    sel  = (round_i > LAST) ? LAST : round_i;
    rc_o = RCON_TBL[sel*ROWW +: ROWW];
  end
endmodule

// File: rtl/kev_const_add.sv
module kev_const_add
  import kev_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int BW   = 8
) (
  input  logic [ROWS*COLS*BW-1:0] din,
  input  logic [COLS*BW-1:0]      rc,
  output logic [ROWS*COLS*BW-1:0] dout
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int LSB = kev_elem_lsb(r, c, ROWS, BW);
      if (r == 0) begin : g_inject
        assign dout[LSB +: BW] = din[LSB +: BW] ^ rc[c*BW +: BW];
      end else begin : g_pass
        assign dout[LSB +: BW] = din[LSB +: BW];
      end
    end
  end
endmodule

// File: rtl/kev_row_rotate.sv
module kev_row_rotate
  import kev_pkg::*;
#(
  parameter int ROWS    = 3,
  parameter int COLS    = 4,
  parameter int BW      = 8,
  parameter bit INVERSE = 1'b0
) (
  input  logic [ROWS*COLS*BW-1:0] din,
  output logic [ROWS*COLS*BW-1:0] dout
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // forward: row 1 one left, row 2 one right, others fixed
    localparam int FWD_AMT = (r == 1) ? 1 : ((r == 2) ? COLS - 1 : 0);
    localparam int AMT     = INVERSE ? (COLS - FWD_AMT) % COLS : FWD_AMT;
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int SRC = (c + AMT) % COLS;
      assign dout[kev_elem_lsb(r, c, ROWS, BW) +: BW] =
             din[kev_elem_lsb(r, SRC, ROWS, BW) +: BW];
    end
  end
endmodule

// File: rtl/kev_evolve.sv
module kev_evolve
  import kev_pkg::*;
#(
  parameter int ROWS   = 3,
  parameter int COLS   = 4,
  parameter int BW     = 8,
  parameter int NCONST = 10,
  localparam int ROWW  = COLS * BW,
  localparam int KEYW  = ROWS * COLS * BW,
  localparam int IDXW  = (NCONST > 1) ? $clog2(NCONST) : 1,
  parameter logic [NCONST*ROWW-1:0] RCON_TBL = {
    32'h5e0b_71c4, 32'h93d6_2a0f, 32'h2c87_e513, 32'h7a41_9fd8,
    32'hc63e_0b57, 32'h18f2_d46a, 32'hb5a9_3c81, 32'h4f70_a2e6,
    32'he21d_58b9, 32'h0936_cf7d}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [KEYW-1:0] key_i,
  input  logic            step_i,
  input  logic            fwd_i,
  input  logic [IDXW-1:0] round_i,
  input  logic [KEYW-1:0] hook_in_i,
  output logic [KEYW-1:0] hook_out_o,
  output logic [KEYW-1:0] key_o
);
  logic            rst_core_n;
  kev_dir_e        dir;
  logic [ROWW-1:0] rc;
  logic [KEYW-1:0] key_q, key_d;
  logic            key_en;
  logic [KEYW-1:0] fwd_added, fwd_rotated;
  logic [KEYW-1:0] bwd_rotated, bwd_added;

  kev_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n));

  kev_rcon_sel #(.NCONST(NCONST), .ROWW(ROWW), .IDXW(IDXW), .RCON_TBL(RCON_TBL))
    u_rcon (.round_i(round_i), .rc_o(rc));

  // forward path: constant, then rotation
  kev_const_add #(.ROWS(ROWS), .COLS(COLS), .BW(BW))
    u_add_fwd (.din(key_q), .rc(rc), .dout(fwd_added));
  kev_row_rotate #(.ROWS(ROWS), .COLS(COLS), .BW(BW), .INVERSE(1'b0))
    u_rot_fwd (.din(fwd_added), .dout(fwd_rotated));

  // backward path: (external inverse mixing), inverse rotation, constant
  kev_row_rotate #(.ROWS(ROWS), .COLS(COLS), .BW(BW), .INVERSE(1'b1))
    u_rot_bwd (.din(hook_in_i), .dout(bwd_rotated));
  kev_const_add #(.ROWS(ROWS), .COLS(COLS), .BW(BW))
    u_add_bwd (.din(bwd_rotated), .rc(rc), .dout(bwd_added));

  always_comb begin
    dir        = kev_dir_e'(fwd_i);
    hook_out_o = (dir == KEV_FWD) ? fwd_rotated : key_q;
    key_en     = load_i | step_i;
    if (load_i)              key_d = key_i;
    else if (dir == KEV_FWD) key_d = hook_in_i;
    else                     key_d = bwd_added;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  key_q <= '0;
    else if (key_en)  key_q <= key_d;
  end

  assign key_o = key_q;
endmodule

// File: rtl/kev_evolve_chk.sv
module kev_evolve_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_i,
  input logic [95:0] key_i,
  input logic        step_i,
  input logic        fwd_i,
  input logic [95:0] hook_in_i,
  input logic [95:0] hook_out_o,
  input logic [95:0] key_o
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> key_o == $past(key_i));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(key_o));

  // R9
  fwd_hook_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && fwd_i) |=> key_o == $past(hook_in_i));

  // R5
  bwd_hook_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_i |-> hook_out_o == key_o);

  // R4: element (1,j) at bits 8(1+3j), (2,j) at bits 8(2+3j)
  fwd_row1_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_i |-> {hook_out_o[15:8], hook_out_o[39:32], hook_out_o[63:56], hook_out_o[87:80]}
           == {key_o[39:32], key_o[63:56], key_o[87:80], key_o[15:8]});

  // R4
  fwd_row2_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_i |-> {hook_out_o[23:16], hook_out_o[47:40], hook_out_o[71:64], hook_out_o[95:88]}
           == {key_o[95:88], key_o[23:16], key_o[47:40], key_o[71:64]});
endmodule

bind kev_evolve kev_evolve_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .load_i(load_i), .key_i(key_i),
  .step_i(step_i), .fwd_i(fwd_i), .hook_in_i(hook_in_i),
  .hook_out_o(hook_out_o), .key_o(key_o)
);

// File: tb/sim_kev_evolve.sv
module sim_kev_evolve;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {fwd, round[3:0], key[95:0]}
  localparam logic [100:0] VEC [NVEC] = '{
    {1'b1, 4'd0,  96'h0011_2233_4455_6677_8899_aabb},
    {1'b1, 4'd5,  96'hffee_ddcc_bbaa_9988_7766_5544},
    {1'b1, 4'd9,  96'h0102_0304_0506_0708_090a_0b0c},
    {1'b1, 4'd12, 96'hdead_beef_cafe_f00d_1234_5678},
    {1'b0, 4'd0,  96'h0011_2233_4455_6677_8899_aabb},
    {1'b0, 4'd3,  96'h8000_0000_0000_0000_0000_0001},
    {1'b0, 4'd9,  96'h5a5a_5a5a_a5a5_a5a5_3c3c_3c3c},
    {1'b0, 4'd15, 96'h0f0e_0d0c_0b0a_0908_0706_0504}
  };

  localparam logic [319:0] RC_TBL = {
    32'h5e0b_71c4, 32'h93d6_2a0f, 32'h2c87_e513, 32'h7a41_9fd8,
    32'hc63e_0b57, 32'h18f2_d46a, 32'hb5a9_3c81, 32'h4f70_a2e6,
    32'he21d_58b9, 32'h0936_cf7d};

  logic        clk = 1'b0;
  logic        rst_n, load_i, step_i, fwd_i;
  logic [3:0]  round_i;
  logic [95:0] key_i, hook_in_i, hook_out_o, key_o, tweak;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign hook_in_i = hook_out_o ^ tweak;

  kev_evolve u0 (.clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i),
    .step_i(step_i), .fwd_i(fwd_i), .round_i(round_i), .hook_in_i(hook_in_i),
    .hook_out_o(hook_out_o), .key_o(key_o));

  function automatic logic [31:0] rc_of(input logic [3:0] r);
    int idx = (r > 4'd9) ? 9 : int'(r);
    return RC_TBL[idx*32 +: 32];
  endfunction

  function automatic logic [7:0] bget(input logic [95:0] k, input int i, input int j);
    return k[8*(i+3*j) +: 8];
  endfunction

  function automatic logic [95:0] m_add(input logic [95:0] k, input logic [31:0] c);
    logic [95:0] o = k;
    for (int j = 0; j < 4; j++) o[8*(3*j) +: 8] = k[8*(3*j) +: 8] ^ c[8*j +: 8];
    return o;
  endfunction

  function automatic logic [95:0] m_fwd(input logic [95:0] k, input logic [3:0] r);
    logic [95:0] t = m_add(k, rc_of(r));
    logic [95:0] o;
    for (int j = 0; j < 4; j++) begin
      o[8*(0+3*j) +: 8] = bget(t, 0, j);
      o[8*(1+3*j) +: 8] = bget(t, 1, (j+1)%4);
      o[8*(2+3*j) +: 8] = bget(t, 2, (j+3)%4);
    end
    return o;
  endfunction

  function automatic logic [95:0] m_bwd(input logic [95:0] k, input logic [3:0] r);
    logic [95:0] o;
    for (int j = 0; j < 4; j++) begin
      o[8*(0+3*j) +: 8] = bget(k, 0, j);
      o[8*(1+3*j) +: 8] = bget(k, 1, (j+3)%4);
      o[8*(2+3*j) +: 8] = bget(k, 2, (j+1)%4);
    end
    return m_add(o, rc_of(r));
  endfunction

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [95:0] k, input logic with_step);
    load_i = 1'b1; key_i = k; step_i = with_step;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
  endtask

  task automatic do_step(input logic fwd, input logic [3:0] r);
    fwd_i = fwd; round_i = r; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [95:0] k0, sv;
    rst_n = 1'b0; load_i = 1'b0; step_i = 1'b0; fwd_i = 1'b1;
    round_i = 4'd0; key_i = '0; tweak = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: cleared after reset
    check("R1 reset", key_o, 96'h0);

    // R2: load captures key
    k0 = 96'h0123_4567_89ab_cdef_fedc_ba98;
    do_load(k0, 1'b0);
    check("R2 load", key_o, k0);

    // table walk: forward steps (R3, R4, R6) and backward steps (R5)
    for (int v = 0; v < NVEC; v++) begin
      do_load(VEC[v][95:0], 1'b0);
      do_step(VEC[v][100], VEC[v][99:96]);
      check(VEC[v][100] ? "R3/R4 fwd step" : "R5 bwd step", key_o,
            VEC[v][100] ? m_fwd(VEC[v][95:0], VEC[v][99:96])
                        : m_bwd(VEC[v][95:0], VEC[v][99:96]));
    end

    // R3: zero key, constant reaches only elements (0,j) = bytes 0,3,6,9
    do_load(96'h0, 1'b0);
    do_step(1'b1, 4'd4);
    check("R3 row0 const", {bget(key_o,0,3), bget(key_o,0,2), bget(key_o,0,1), bget(key_o,0,0)},
          {64'h0, rc_of(4'd4)});
    check("R3 rows1-2 untouched", key_o & ~96'hff_0000_ff00_00ff_0000_ff, 96'h0);

    // R4: hook output shows forward rotation of a ramp key
    k0 = 96'h0b0a_0908_0706_0504_0302_0100;
    do_load(k0, 1'b0);
    fwd_i = 1'b1; round_i = 4'd1;
    #1;
    check("R4 hook rotate", hook_out_o, m_fwd(k0, 4'd1));

    // R5: backward mode hook output is current key
    fwd_i = 1'b0;
    #1;
    check("R5 hook src", hook_out_o, k0);
    @(negedge clk);

    // R6: round 13 gives the same result as round 9
    do_load(k0, 1'b0);
    do_step(1'b1, 4'd13);
    sv = key_o;
    do_load(k0, 1'b0);
    do_step(1'b1, 4'd9);
    check("R6 saturate", sv, key_o);

    // R7: idle cycles keep the key
    sv = key_o;
    repeat (3) @(negedge clk);
    check("R7 hold", key_o, sv);

    // R2: load wins over step
    do_load(96'hcafe_0000_1111_2222_3333_4444, 1'b1);
    check("R2 load priority", key_o, 96'hcafe_0000_1111_2222_3333_4444);

    // R8: forward then backward restores
    for (int r = 0; r < 16; r += 5) begin
      k0 = 96'h1357_9bdf_2468_ace0_f0e1_d2c3 ^ {r[7:0], 88'h0};
      do_load(k0, 1'b0);
      do_step(1'b1, r[3:0]);
      do_step(1'b0, r[3:0]);
      check("R8 round trip", key_o, k0);
    end

    // R9: forward step takes the mixing result as given
    tweak = 96'h0000_ffff_0000_ffff_0000_ffff;
    do_load(k0, 1'b0);
    do_step(1'b1, 4'd2);
    check("R9 hook take", key_o, m_fwd(k0, 4'd2) ^ tweak);
    tweak = '0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule